// File: doc/BRIEF.md
# Two-Thread Interleaved Instruction Fetch

This block is the fetch stage of a five-stage in-order pipeline that runs two hardware threads in fine-grained interleave. It holds one program counter per thread and serves them on a strict alternating schedule. Thread 0 owns every even cycle after reset and thread 1 owns every odd cycle. Each fetched instruction leaves the stage tagged with its thread number. Later stages use that tag to select the matching register bank. Two neighbouring pipeline stages therefore never hold instructions of the same thread, so no register dependence can exist between them and no forwarding path between them is needed.

The instruction memory sits outside the block. It is read combinationally at the address the block presents in the same cycle. Downstream logic can hold back either thread with a per-thread stall request. It can also redirect one thread to a new target after a branch resolves. A redirect changes only the named thread's counter. It raises a per-thread squash line so that the later stages kill that thread's younger instructions.

A two-state parity machine sets the schedule. State `SLOT_T0` always moves to `SLOT_T1`, and `SLOT_T1` always moves back to `SLOT_T0`. Reset places the machine in `SLOT_T0`. No input changes these transitions.

Top module: `ilv_fetch`

## Requirements
- R1: While reset is asserted and right after it is released, `fetch_valid` is 0, thread 0's counter holds `RESET_VEC0` and thread 1's holds `RESET_VEC1`, and the first slot belongs to thread 0, so `imem_addr` equals `RESET_VEC0`.
- R2: The slot owner alternates 0,1,0,1,… every cycle, whatever the stall and redirect inputs do. An instruction issued from a slot carries that slot's thread number on `fetch_tid` (0 or 1).
- R3: An issued slot appears one clock later on the output register: `fetch_valid`=1, `fetch_pc` = the owning thread's counter and `fetch_instr` = the `imem_data` read at that address.
- R4: In every cycle `imem_addr` equals the counter of the thread that owns the cycle. After a thread issues without a redirect, its counter grows by 4.
- R5: If `hold_req[t]` is 1 in thread t's slot, the slot yields a bubble (`fetch_valid`=0 one cycle later) and thread t's counter stays unchanged. The slot is not given to the other thread.
- R6: A redirect (`redir_valid`=1) loads `redir_target` into the counter of thread `redir_tid` only. The other thread's counter behaves as if no redirect were present.
- R7: A redirect naming the thread that owns the current slot turns that slot into a bubble, and the thread's next slot fetches from the target.
- R8: `squash_mask` bit t is 1 exactly when `redir_valid` is 1 and `redir_tid`=t, in the same cycle.
- R9: Two valid outputs on consecutive cycles never carry the same thread number.
- R10: A redirect takes precedence over both the stall and the +4 advance for the named thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_req | input | 2 | Per-thread stall request, bit t for thread t |
| redir_valid | input | 1 | Redirect present this cycle |
| redir_tid | input | 1 | Thread the redirect applies to |
| redir_target | input | ADDR_W | New counter value for that thread |
| imem_addr | output | ADDR_W | Fetch address of the current slot |
| imem_data | input | INSTR_W | Instruction word read at `imem_addr` |
| fetch_valid | output | 1 | Output register holds a live instruction |
| fetch_tid | output | 1 | Thread number of the held instruction |
| fetch_pc | output | ADDR_W | Address of the held instruction |
| fetch_instr | output | INSTR_W | Held instruction word |
| squash_mask | output | 2 | Per-thread kill request to later stages |

## Verification
A wrong parity state shows up at once on `imem_addr`, which presents the other thread's counter in the same cycle. One cycle later it shows up as a repeated thread number on two consecutive valid outputs. A corrupted counter shows up in that thread's next slot, at most two cycles later, as a wrong fetch address and a wrong `fetch_pc`. A wrong issue decision, such as a missed bubble or a stalled thread that still advances, shows up one cycle after the slot on `fetch_valid`. It also shifts every later address of that thread.

// File: rtl/ilv_fetch_pkg.sv
package ilv_fetch_pkg;

    localparam int unsigned THREADS = 2;
    localparam int unsigned TID_W   = 1;
    localparam int unsigned PC_STEP = 4;

    typedef enum logic [0:0] {
        SLOT_T0 = 1'b0,
        SLOT_T1 = 1'b1
    } slot_e;

endpackage

// File: rtl/ilv_slot_fsm.sv
module ilv_slot_fsm
    import ilv_fetch_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    output logic [TID_W-1:0] slot_tid
);

    slot_e state_q;
    slot_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_T0: state_d = SLOT_T1;
            SLOT_T1: state_d = SLOT_T0;
            default: state_d = SLOT_T0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_T0;
        else        state_q <= state_d;
    end

    always_comb begin
        slot_tid = '0;
        unique case (state_q)
            SLOT_T0: slot_tid = TID_W'(0);
            SLOT_T1: slot_tid = TID_W'(1);
            default: slot_tid = TID_W'(0);
        endcase
    end

    assert_slot_alternates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> slot_tid != $past(slot_tid));

endmodule

// File: rtl/ilv_pc_unit.sv
module ilv_pc_unit
    import ilv_fetch_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              load,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;

    always_comb begin
        if (load)         pc_d = target;
        else if (advance) pc_d = pc_q + STEP;
        else              pc_d = pc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= RESET_VEC;
        else        pc_q <= pc_d;
    end

    assign pc = pc_q;

    assert_pc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> pc == $past(pc) + STEP);

    assert_pc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load) |=> $stable(pc));

    assert_redirect_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> pc == $past(target));

endmodule

// File: rtl/ilv_issue_reg.sv
module ilv_issue_reg
    import ilv_fetch_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned INSTR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue,
    input  logic [TID_W-1:0]   issue_tid,
    input  logic [ADDR_W-1:0]  issue_pc,
    input  logic [INSTR_W-1:0] issue_instr,
    output logic               out_valid,
    output logic [TID_W-1:0]   out_tid,
    output logic [ADDR_W-1:0]  out_pc,
    output logic [INSTR_W-1:0] out_instr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tid   <= '0;
            out_pc    <= '0;
            out_instr <= '0;
        end else begin
            out_valid <= issue;
            if (issue) begin
                out_tid   <= issue_tid;
                out_pc    <= issue_pc;
                out_instr <= issue_instr;
            end
        end
    end

    assert_adjacent_differ_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> out_tid != $past(out_tid));

endmodule

// File: rtl/ilv_fetch.sv
module ilv_fetch
    import ilv_fetch_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 32,
    parameter int unsigned       INSTR_W    = 32,
    parameter logic [ADDR_W-1:0] RESET_VEC0 = 32'h0000_1000,
    parameter logic [ADDR_W-1:0] RESET_VEC1 = 32'h0000_2000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [THREADS-1:0]   hold_req,
    input  logic                 redir_valid,
    input  logic [TID_W-1:0]     redir_tid,
    input  logic [ADDR_W-1:0]    redir_target,
    output logic [ADDR_W-1:0]    imem_addr,
    input  logic [INSTR_W-1:0]   imem_data,
    output logic                 fetch_valid,
    output logic [TID_W-1:0]     fetch_tid,
    output logic [ADDR_W-1:0]    fetch_pc,
    output logic [INSTR_W-1:0]   fetch_instr,
    output logic [THREADS-1:0]   squash_mask
);

    logic [TID_W-1:0]  slot_tid;
    logic              slot_redirected;
    logic              slot_issue;
    logic [ADDR_W-1:0] pc_of [THREADS];

    ilv_slot_fsm u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_tid (slot_tid)
    );

    assign slot_redirected = redir_valid && (redir_tid == slot_tid);
    assign slot_issue      = !hold_req[slot_tid] && !slot_redirected;

    for (genvar t = 0; t < THREADS; t++) begin : g_thread
        localparam logic [TID_W-1:0] MY_TID = TID_W'(t);
        localparam logic [ADDR_W-1:0] MY_VEC = (t == 0) ? RESET_VEC0 : RESET_VEC1;

        logic owns_slot;
        logic hit;

        assign owns_slot      = (slot_tid == MY_TID);
        assign hit            = redir_valid && (redir_tid == MY_TID);
        assign squash_mask[t] = hit;

        ilv_pc_unit #(
            .ADDR_W    (ADDR_W),
            .RESET_VEC (MY_VEC)
        ) u_pc (
            .clk     (clk),
            .rst_n   (rst_n),
            .advance (slot_issue && owns_slot),
            .load    (hit),
            .target  (redir_target),
            .pc      (pc_of[t])
        );
    end

    assign imem_addr = pc_of[slot_tid];

    ilv_issue_reg #(
        .ADDR_W  (ADDR_W),
        .INSTR_W (INSTR_W)
    ) u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue       (slot_issue),
        .issue_tid   (slot_tid),
        .issue_pc    (imem_addr),
        .issue_instr (imem_data),
        .out_valid   (fetch_valid),
        .out_tid     (fetch_tid),
        .out_pc      (fetch_pc),
        .out_instr   (fetch_instr)
    );

    assert_stall_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req[slot_tid] |=> !fetch_valid);

    assert_own_slot_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && redir_tid == slot_tid) |=> !fetch_valid);

    assert_squash_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(squash_mask) && (redir_valid == (squash_mask != '0)));

    assert_tag_other_thread_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> fetch_tid != slot_tid);

endmodule

// File: tb/test_ilv_fetch.sv
module test_ilv_fetch;

    localparam logic [31:0] RV0 = 32'h0000_1000;
    localparam logic [31:0] RV1 = 32'h0000_2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  hold_req = '0;
    logic        redir_valid = 1'b0;
    logic        redir_tid = 1'b0;
    logic [31:0] redir_target = '0;
    logic [31:0] imem_addr;
    logic [31:0] imem_data;
    logic        fetch_valid;
    logic        fetch_tid;
    logic [31:0] fetch_pc;
    logic [31:0] fetch_instr;
    logic [1:0]  squash_mask;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_pc [2];
    logic        m_slot;
    logic        prev_valid;
    logic        prev_tid;

    always #10 clk = ~clk;

    function automatic logic [31:0] rom(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
    endfunction

    assign imem_data = rom(imem_addr);

    ilv_fetch #(
        .ADDR_W     (32),
        .INSTR_W    (32),
        .RESET_VEC0 (RV0),
        .RESET_VEC1 (RV1)
    ) i_ilv_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .hold_req     (hold_req),
        .redir_valid  (redir_valid),
        .redir_tid    (redir_tid),
        .redir_target (redir_target),
        .imem_addr    (imem_addr),
        .imem_data    (imem_data),
        .fetch_valid  (fetch_valid),
        .fetch_tid    (fetch_tid),
        .fetch_pc     (fetch_pc),
        .fetch_instr  (fetch_instr),
        .squash_mask  (squash_mask)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // One cycle: drive at negedge, check address and squash, model the edge, check outputs.
    task automatic step(input logic [1:0] st, input logic rv, input logic rt,
                        input logic [31:0] tg);
        logic t;
        logic fire;
        logic [31:0] ep;
        hold_req     = st;
        redir_valid  = rv;
        redir_tid    = rt;
        redir_target = tg;
        #1;
        t = m_slot;
        chk("R4/R6 slot address", imem_addr, m_pc[t]);
        chk("R8 squash mask", {30'b0, squash_mask}, rv ? (32'd1 << rt) : 32'd0);
        fire = !st[t] && !(rv && rt == t);
        ep   = m_pc[t];
        if (fire) m_pc[t] = m_pc[t] + 32'd4;
        if (rv) m_pc[rt] = tg;
        m_slot = ~m_slot;
        @(negedge clk);
        chk("R5/R7 issue valid", {31'b0, fetch_valid}, {31'b0, fire});
        if (fire) begin
            chk("R2 thread tag", {31'b0, fetch_tid}, {31'b0, t});
            chk("R3 fetch pc", fetch_pc, ep);
            chk("R3 fetch instr", fetch_instr, rom(ep));
            if (prev_valid) chk("R9 adjacent threads differ", {31'b0, fetch_tid != prev_tid}, 32'd1);
        end
        prev_valid = fetch_valid;
        prev_tid   = fetch_tid;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        logic [31:0] tgt;
        tgt = 32'h0000_4000;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 valid in reset", {31'b0, fetch_valid}, 32'd0);
        chk("R1 first slot address", imem_addr, RV0);
        rst_n = 1'b1;
        m_pc[0] = RV0;
        m_pc[1] = RV1;
        m_slot = 1'b0;
        prev_valid = 1'b0;
        prev_tid = 1'b0;
        #1;
        chk("R1 address after release", imem_addr, RV0);
        chk("R1 valid after release", {31'b0, fetch_valid}, 32'd0);
        @(negedge clk);
        // the first edge after release was a thread 0 slot with no stall
        m_pc[0] = RV0 + 32'd4;
        m_slot = 1'b1;
        chk("R1 first issue from thread 0", {31'b0, fetch_valid, fetch_tid}, 32'b10);
        chk("R1 first issue pc", fetch_pc, RV0);
        prev_valid = fetch_valid;
        prev_tid = fetch_tid;

        // R2 R4 R5: all stall pairs over both parities
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
                step(a[1:0], 1'b0, 1'b0, '0);
                step(b[1:0], 1'b0, 1'b0, '0);
            end
        step(2'b00, 1'b0, 1'b0, '0);

        // R6 R7 R10: redirect each thread at each parity with every stall pair
        for (int rt = 0; rt < 2; rt++)
            for (int ph = 0; ph < 2; ph++)
                for (int s = 0; s < 4; s++) begin
                    if (m_slot != ph[0]) step(2'b00, 1'b0, 1'b0, '0);
                    tgt = tgt + 32'h10;
                    step(s[1:0], 1'b1, rt[0], tgt);
                    step(2'b00, 1'b0, 1'b0, '0);
                    step(2'b00, 1'b0, 1'b0, '0);
                    step(2'b00, 1'b0, 1'b0, '0);
                end

        // R10: stalled own-slot redirect still lands on the target
        if (m_slot != 1'b0) step(2'b00, 1'b0, 1'b0, '0);
        step(2'b11, 1'b1, 1'b0, 32'h0000_8800);
        step(2'b00, 1'b0, 1'b0, '0);
        #1;
        chk("R10 redirect over stall", imem_addr, 32'h0000_8800);
        @(negedge clk);
        hold_req = 2'b00;
        summary();
    end

endmodule